// File: doc/BRIEF.md
# Interrupt State Save/Restore Unit

This block keeps the processor state needed to come back from a non-critical interrupt. When the core takes such an interrupt, the block stores a word-aligned return address and a copy of the machine-state word. In the same clock edge it clears the live machine-state word. When a return-from-interrupt executes, the block presents the stored address as the next fetch target and reloads the machine-state word from the stored copy.

Software reaches both stored registers through a special-register move port. A one-bit select picks the register. Writes are synchronous and reads are combinational. The two lowest address bits are not implemented: they always read as zero and drop whatever is written to them. The stored state copy keeps all 32 bits, including positions that are unused in the machine-state word. A return therefore restores those positions exactly as they were saved.

Top module: `isr_state_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the return-address register, the state-copy register and the machine-state output `msrOut` to zero.
- R2: When `takeIrq` is high at a clock edge, the following three updates happen at that edge:
  - the return-address register takes `irqRetAddr` with bits 1:0 forced to zero;
  - the state-copy register takes the value `msrOut` had before that edge;
  - `msrOut` becomes zero.
- R3: While `doReturn` is high, `resumeValid` is high in the same cycle and `resumeAddr` shows the stored return address. `resumeValid` is low in every other cycle.
- R4: When `doReturn` is high at a clock edge, `msrOut` takes all 32 bits of the state-copy register. This includes bits that software treats as reserved.
- R5: When `sprWrEn` is high at an edge, `sprWrData` is written to the register chosen by `sprSel`. Select 0 chooses the return-address register and select 1 chooses the state copy.
- R6: `sprRdData` shows the register chosen by `sprSel` in the same cycle. Bits 1:0 of the return-address register always read as zero, and writes to those bits have no effect.
- R7: If `takeIrq` and `sprWrEn` are high in the same cycle, the interrupt capture is stored and the software write is dropped. This holds for either select value.
- R8: A software write to the state copy in the same cycle as `doReturn` stores the new data in the state copy. `msrOut` still receives the value the state copy held before that edge.
- R9: `takeIrq` and `doReturn` are never high in the same cycle. When `takeIrq` is high, `resumeValid` stays low.
- R10: When neither `takeIrq` nor `sprWrEn` is high, both stored registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| takeIrq | input | 1 | Non-critical interrupt taken this cycle |
| irqRetAddr | input | 32 | Return address to capture on interrupt |
| doReturn | input | 1 | Return-from-interrupt executes this cycle |
| resumeValid | output | 1 | Next fetch address comes from `resumeAddr` |
| resumeAddr | output | 32 | Stored return address |
| msrOut | output | 32 | Live machine-state word |
| sprWrEn | input | 1 | Special-register write strobe |
| sprSel | input | 1 | Register select: 0 address, 1 state copy |
| sprWrData | input | 32 | Special-register write data |
| sprRdData | output | 32 | Special-register read data |

## Verification
The assertions assume that the pipeline never raises `takeIrq` and `doReturn` together. One assertion reports any cycle where both are high. The stimulus drives at most one of the two event inputs in any cycle. It still combines each of them with a software write in the same cycle, so that the priority and old-value rules are exercised. The capture and restore properties compare a register with what its source held one cycle earlier. For that reason they are disabled while reset is high.

// File: rtl/isr_pkg.sv
`timescale 1ns/1ps
package isr_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;
    logic restore;
    logic wrAddr;
    logic wrState;
  } isrStrobe_t;

  localparam logic SEL_ADDR  = 1'b0;
  localparam logic SEL_STATE = 1'b1;
endpackage

// File: rtl/isr_ctrl.sv
`timescale 1ns/1ps
module isr_ctrl
  import isr_pkg::*;
(
  input  logic       takeIrq,
  input  logic       doReturn,
  input  logic       sprWrEn,
  input  logic       sprSel,
  output isrStrobe_t strobe,
  output logic       resumeValid
);
  always_comb begin
    strobe.capture = takeIrq;
    // Restore is suppressed if an interrupt is (illegally) present too
    strobe.restore = doReturn & ~takeIrq;
    // Interrupt capture wins over any software write
    strobe.wrAddr  = sprWrEn & (sprSel == SEL_ADDR)  & ~takeIrq;
    strobe.wrState = sprWrEn & (sprSel == SEL_STATE) & ~takeIrq;
    resumeValid    = strobe.restore;
  end
endmodule

// File: rtl/isr_dpath.sv
`timescale 1ns/1ps
module isr_dpath
  import isr_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int RSV_LSB = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  isrStrobe_t      strobe,
  input  logic [XLEN-1:0] irqRetAddr,
  input  logic [XLEN-1:0] sprWrData,
  input  logic            sprSel,
  output logic [XLEN-1:0] addrQ,
  output logic [XLEN-1:0] stateQ,
  output logic [XLEN-1:0] msrQ,
  output logic [XLEN-1:0] sprRdData
);
  localparam logic [XLEN-1:0] LOW_ONES  = (XLEN'(1) << RSV_LSB) - XLEN'(1);
  localparam logic [XLEN-1:0] ADDR_MASK = ~LOW_ONES;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      stateQ <= '0;
      msrQ   <= '0;
    end else if (strobe.capture) begin
      addrQ  <= irqRetAddr & ADDR_MASK;
      stateQ <= msrQ;
      msrQ   <= '0;
    end else begin
      if (strobe.wrAddr)  addrQ  <= sprWrData & ADDR_MASK;
      if (strobe.wrState) stateQ <= sprWrData;
      if (strobe.restore) msrQ   <= stateQ;
    end
  end

  always_comb begin
    sprRdData = (sprSel == SEL_STATE) ? stateQ : addrQ;
  end
endmodule

// File: rtl/isr_state_unit.sv
`timescale 1ns/1ps
module isr_state_unit
  import isr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        takeIrq,
  input  logic [31:0] irqRetAddr,
  input  logic        doReturn,
  output logic        resumeValid,
  output logic [31:0] resumeAddr,
  output logic [31:0] msrOut,
  input  logic        sprWrEn,
  input  logic        sprSel,
  input  logic [31:0] sprWrData,
  output logic [31:0] sprRdData
);
  localparam int XLEN    = 32;
  localparam int RSV_LSB = 2;

  isrStrobe_t      strobe;
  logic [XLEN-1:0] addrQ;
  logic [XLEN-1:0] stateQ;

  isr_ctrl u_ctrl (
    .takeIrq    (takeIrq),
    .doReturn   (doReturn),
    .sprWrEn    (sprWrEn),
    .sprSel     (sprSel),
    .strobe     (strobe),
    .resumeValid(resumeValid)
  );

  isr_dpath #(.XLEN(XLEN), .RSV_LSB(RSV_LSB)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .irqRetAddr(irqRetAddr),
    .sprWrData (sprWrData),
    .sprSel    (sprSel),
    .addrQ     (addrQ),
    .stateQ    (stateQ),
    .msrQ      (msrOut),
    .sprRdData (sprRdData)
  );

  assign resumeAddr = addrQ;
endmodule

// File: rtl/isr_state_unit_chk.sv
`timescale 1ns/1ps
module isr_state_unit_chk #(
  parameter int XLEN    = 32,
  parameter int RSV_LSB = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            takeIrq,
  input logic            doReturn,
  input logic [XLEN-1:0] irqRetAddr,
  input logic            sprWrEn,
  input logic            sprSel,
  input logic [XLEN-1:0] sprWrData,
  input logic [XLEN-1:0] addrQ,
  input logic [XLEN-1:0] stateQ,
  input logic [XLEN-1:0] msrOut
);
  localparam logic [XLEN-1:0] KEEP = ~((XLEN'(1) << RSV_LSB) - XLEN'(1));

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(takeIrq && doReturn)); // R9
  AST_CAPTURE_STATE: assert property (@(posedge clk) disable iff (rst)
    takeIrq |=> stateQ == $past(msrOut)); // R2
  AST_CAPTURE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    takeIrq |=> msrOut == '0); // R2
  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (rst)
    takeIrq |=> addrQ == ($past(irqRetAddr) & KEEP)); // R7
  AST_RESTORE_STATE: assert property (@(posedge clk) disable iff (rst)
    (doReturn && !takeIrq) |=> msrOut == $past(stateQ)); // R4
  AST_STATE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (sprWrEn && sprSel && !takeIrq) |=> stateQ == $past(sprWrData)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!takeIrq && !sprWrEn) |=> $stable(addrQ) && $stable(stateQ)); // R10
endmodule

bind isr_state_unit isr_state_unit_chk #(.XLEN(XLEN), .RSV_LSB(RSV_LSB)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .takeIrq   (takeIrq),
  .doReturn  (doReturn),
  .irqRetAddr(irqRetAddr),
  .sprWrEn   (sprWrEn),
  .sprSel    (sprSel),
  .sprWrData (sprWrData),
  .addrQ     (addrQ),
  .stateQ    (stateQ),
  .msrOut    (msrOut)
);

// File: tb/tb_isr_state_unit.sv
`timescale 1ns/1ps
module tb_isr_state_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        takeIrq = 1'b0;
  logic [31:0] irqRetAddr = '0;
  logic        doReturn = 1'b0;
  logic        resumeValid;
  logic [31:0] resumeAddr;
  logic [31:0] msrOut;
  logic        sprWrEn = 1'b0;
  logic        sprSel = 1'b0;
  logic [31:0] sprWrData = '0;
  logic [31:0] sprRdData;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  isr_state_unit dut (
    .clk(clk), .rst(rst), .takeIrq(takeIrq), .irqRetAddr(irqRetAddr),
    .doReturn(doReturn), .resumeValid(resumeValid), .resumeAddr(resumeAddr),
    .msrOut(msrOut), .sprWrEn(sprWrEn), .sprSel(sprSel),
    .sprWrData(sprWrData), .sprRdData(sprRdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idleIn();
    takeIrq = 0; doReturn = 0; sprWrEn = 0; sprSel = 0;
    irqRetAddr = '0; sprWrData = '0;
  endtask

  task automatic readReg(input logic sel, output logic [31:0] val);
    sprSel = sel;
    #1;
    val = sprRdData;
  endtask

  task automatic sprWrite(input logic sel, input logic [31:0] data);
    sprWrEn = 1; sprSel = sel; sprWrData = data;
    tick();
    idleIn();
  endtask

  task automatic doReset();
    rst = 1; idleIn();
    tick(); tick();
    rst = 0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    readReg(0, v); check("R1 addr after reset", v, 32'h0);
    readReg(1, v); check("R1 state after reset", v, 32'h0);
    check("R1 msr after reset", msrOut, 32'h0);
    check("R3 no resume when idle", {31'b0, resumeValid}, 32'h0);
  endtask

  task automatic testSprAccess();
    logic [31:0] v;
    sprWrite(0, 32'hDEADBEEF);
    readReg(0, v); check("R6 addr low bits read zero", v, 32'hDEADBEEC);
    sprWrite(1, 32'h80000003);
    readReg(1, v); check("R5 state write full width", v, 32'h80000003);
    sprWrite(0, 32'h00000003);
    readReg(0, v); check("R6 low-bit-only write ignored", v, 32'h0);
    check("R5 msr untouched by spr writes", msrOut, 32'h0);
  endtask

  task automatic testRestore();
    logic [31:0] v;
    sprWrite(1, 32'hA5A50F0F);
    sprWrite(0, 32'h00001000);
    doReturn = 1; sprWrEn = 1; sprSel = 1; sprWrData = 32'h11111111;
    #1;
    check("R3 resumeValid during return", {31'b0, resumeValid}, 32'h1);
    check("R3 resumeAddr during return", resumeAddr, 32'h00001000);
    tick();
    idleIn();
    check("R4 msr reloaded incl reserved bits", msrOut, 32'hA5A50F0F);
    readReg(1, v); check("R8 state takes same-cycle write", v, 32'h11111111);
    check("R3 resumeValid drops after return", {31'b0, resumeValid}, 32'h0);
  endtask

  task automatic testCapture();
    logic [31:0] v;
    takeIrq = 1; irqRetAddr = 32'h12345677;
    sprWrEn = 1; sprSel = 0; sprWrData = 32'hFFFFFFFF;
    #1;
    check("R9 no resume during interrupt", {31'b0, resumeValid}, 32'h0);
    tick();
    idleIn();
    check("R2 msr cleared on capture", msrOut, 32'h0);
    readReg(1, v); check("R2 state holds pre-capture msr", v, 32'hA5A50F0F);
    readReg(0, v); check("R7 capture beats addr write", v, 32'h12345674);
    // second capture, now against a state write: msr is zero
    takeIrq = 1; irqRetAddr = 32'h00000208;
    sprWrEn = 1; sprSel = 1; sprWrData = 32'hCAFEF00D;
    tick();
    idleIn();
    readReg(1, v); check("R7 capture beats state write", v, 32'h0);
    readReg(0, v); check("R2 second capture addr", v, 32'h00000208);
  endtask

  task automatic testHold();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) begin
      sprSel = i[0];
      sprWrData = 32'h5A5A5A5A;
      tick();
    end
    idleIn();
    readReg(0, v); check("R10 addr holds when idle", v, 32'h00000208);
    readReg(1, v); check("R10 state holds when idle", v, 32'h0);
  endtask

  task automatic testRoundTrip();
    sprWrite(1, 32'h00008030);
    doReturn = 1; tick(); idleIn();
    check("R4 msr after first return", msrOut, 32'h00008030);
    takeIrq = 1; irqRetAddr = 32'h00000402; tick(); idleIn();
    check("R2 msr cleared in round trip", msrOut, 32'h0);
    doReturn = 1;
    #1;
    check("R3 resume address in round trip", resumeAddr, 32'h00000400);
    tick(); idleIn();
    check("R4 msr restored in round trip", msrOut, 32'h00008030);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    testReset();
    testSprAccess();
    testRestore();
    testCapture();
    testHold();
    testRoundTrip();
    doReset();
    testReset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule